// File: doc/BRIEF.md
# Prescaler-Selectable PWM Timer

A single-channel pulse-width modulator with two byte-wide registers. A control register holds an enable flag and a 2-bit prescaler. A duty register holds a 7-bit on-time. An 8-bit counter steps once for each pulse on a slow tick input, which is a one-cycle enable synchronous to the system clock and nominally 32 kHz.

The prescaler does not divide anything. It chooses which counter bit acts as the wrap bit. When that bit would become set, the counter returns to zero instead, so the period is 128, 64, 32 or 16 ticks. The output is high while the counter bits below the wrap bit hold a value smaller than the duty value. Writes to either register act at once. The counter is not cleared on a prescaler change, and nothing waits for the end of a period.

The output is a register that is updated on each tick. A duty value equal to or larger than the period length gives a constant high level. At prescaler 0 such a value cannot be written, because the duty field stops at 127.

Top module: `pwm_timer`

## Requirements
- R1: After reset both registers read 0, the counter is 0 and `pwm_out` is low.
- R2: Register at `addr`=0 holds enable in bit 7 and prescaler in bits [1:0]; bits [6:2] read 0. Register at `addr`=1 holds duty in bits [6:0]; bit 7 reads 0. Reads are combinational.
- R3: While enabled, each tick advances the counter by one; with prescaler p the counter clears to 0 instead of setting bit 7-p, so rising edges of `pwm_out` are 128, 64, 32 or 16 ticks apart for p = 0..3.
- R4: For 0 < duty < period, `pwm_out` is high for exactly duty ticks of every period.
- R5: A duty value of at least the period length keeps `pwm_out` high on every tick.
- R6: A duty value of 0 keeps `pwm_out` low.
- R7: With enable at 0 the counter is held at 0 and `pwm_out` is low from the edge that writes enable low; both registers stay writable and readable.
- R8: Writing a new prescaler does not reset the counter: counting continues from its current value.
- R9: A new duty value changes `pwm_out` only at the next tick, not at the write.
- R10: Without a tick the counter and `pwm_out` do not change, except when enable is written low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle time-base pulse |
| we | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control, 1 duty |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| pwm_out | output | 1 | PWM output |

## Verification
A wrong counter value shows at `pwm_out` on the tick where the compare with the duty value first gives a different result. It can stay hidden for up to one period of 16 to 128 ticks, for example when duty is 0 or saturated. For that reason the reference model is compared on every clock, and the high-time and edge spacing are also measured over whole periods for each prescaler. A register that holds a wrong value shows at `rdata` in the same cycle it is selected.

// File: rtl/pwm_timer.sv
module pwm_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       we,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       pwm_out
);
  logic       en_q;
  logic [1:0] presc_q;
  logic [6:0] duty_q;
  logic [7:0] cnt_q;

  wire        ctrl_wr = we && !addr;
  wire        duty_wr = we && addr;
  wire        en_nx   = ctrl_wr ? wdata[7] : en_q;
  wire  [7:0] wrap    = 8'h80 >> presc_q;
  wire  [7:0] inc     = cnt_q + 8'd1;
  wire  [7:0] cnt_nx  = ((inc & wrap) != 8'd0) ? 8'd0 : inc;
  wire        hit     = (cnt_nx & (wrap - 8'd1)) < {1'b0, duty_q};

  assign rdata = addr ? {1'b0, duty_q} : {en_q, 5'b0, presc_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      presc_q <= 2'd0;
      duty_q  <= 7'd0;
      cnt_q   <= 8'd0;
      pwm_out <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en_q    <= wdata[7];
        presc_q <= wdata[1:0];
      end
      if (duty_wr) duty_q <= wdata[6:0];
      if (!en_nx) begin
        cnt_q   <= 8'd0;
        pwm_out <= 1'b0;
      end else if (tick) begin
        cnt_q   <= cnt_nx;
        pwm_out <= hit;
      end
    end
  end
endmodule

module pwm_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       we,
  input logic       addr,
  input logic       en_q,
  input logic [1:0] presc_q,
  input logic [6:0] duty_q,
  input logic [7:0] cnt_q,
  input logic       pwm_out
);
  wire ctrl_wr = we && !addr;

  p_off_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (cnt_q == 8'd0 && !pwm_out));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (cnt_q == $past(cnt_q) || cnt_q == 8'd0));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en_q && !ctrl_wr) |=> (cnt_q == $past(cnt_q) + 8'd1 || cnt_q == 8'd0));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en_q) |=> (((cnt_q >> (3'd7 - {1'b0, $past(presc_q)})) & 8'd1) == 8'd0));

  p_zero_duty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && duty_q == 7'd0) |=> !pwm_out);

  p_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en_q && !ctrl_wr && ({1'b0, duty_q} >= (8'd128 >> presc_q))) |=> pwm_out);

  p_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ctrl_wr) |=> $stable(pwm_out));
endmodule

bind pwm_timer pwm_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .we(we), .addr(addr),
  .en_q(en_q), .presc_q(presc_q), .duty_q(duty_q), .cnt_q(cnt_q),
  .pwm_out(pwm_out)
);

// File: tb/pwm_timer_test.sv
`timescale 1ns/100ps
module pwm_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       we = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       pwm_out;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // reference model state
  int m_en = 0, m_p = 0, m_duty = 0, m_cnt = 0, m_out = 0;

  pwm_timer uut (.clk(clk), .rst_n(rst_n), .tick(tick), .we(we), .addr(addr),
                 .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_en = 0; m_p = 0; m_duty = 0; m_cnt = 0; m_out = 0;
    end else begin
      int per, nxt, new_en;
      per = 128 >> m_p;
      new_en = (we && !addr) ? int'(wdata[7]) : m_en;
      if (!new_en) begin
        m_cnt = 0; m_out = 0;
      end else if (tick) begin
        nxt = m_cnt + 1;
        if (((nxt / per) % 2) == 1) nxt = 0;
        m_cnt = nxt;
        m_out = ((nxt % per) < m_duty) ? 1 : 0;
      end
      if (we && !addr) begin m_en = wdata[7]; m_p = wdata[1:0]; end
      if (we && addr) m_duty = wdata[6:0];
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R3/R4 model pwm_out", pwm_out, m_out);
      check("R2 model rdata", rdata, addr ? m_duty : (m_en * 128 + m_p));
    end
  end

  initial begin
    while (cycles < 150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(posedge clk); #1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(posedge clk); #1; addr = a; #1; d = rdata;
  endtask

  task automatic pulse();
    @(posedge clk); #1; tick = 1'b1;
    @(posedge clk); #1; tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic measure(input int p, input int duty);
    int per, hi, gap, prev;
    per = 128 >> p;
    wr(1'b0, 8'h00);
    wr(1'b1, duty[7:0]);
    wr(1'b0, 8'h80 | p[7:0]);
    for (int i = 0; i < per; i++) pulse();
    hi = 0;
    for (int i = 0; i < per; i++) begin pulse(); if (pwm_out) hi++; end
    if (duty == 0) check("R6 high ticks per period", hi, 0);
    else if (duty >= per) check("R5 high ticks per period", hi, per);
    else check("R4 high ticks per period", hi, duty);
    if (duty > 0 && duty < per) begin
      prev = pwm_out;
      for (int i = 0; i < 3 * per; i++) begin
        pulse();
        if (pwm_out && !prev) break;
        prev = pwm_out;
      end
      gap = 0;
      prev = pwm_out;
      for (int i = 0; i < 3 * per; i++) begin
        pulse(); gap++;
        if (pwm_out && !prev) break;
        prev = pwm_out;
      end
      check("R3 ticks between rising edges", gap, per);
    end
  endtask

  initial begin
    logic [7:0] d;
    idle(4);
    #1 rst_n = 1'b1;
    rd(1'b0, d); check("R1 control after reset", d, 0);
    rd(1'b1, d); check("R1 duty after reset", d, 0);
    check("R1 pwm_out after reset", pwm_out, 0);

    wr(1'b0, 8'h7E);
    rd(1'b0, d); check("R2 control unused bits read 0", d, 8'h02);
    wr(1'b1, 8'hFF);
    rd(1'b1, d); check("R2 duty bit 7 reads 0", d, 8'h7F);
    wr(1'b0, 8'h83);
    rd(1'b0, d); check("R2 control enable and prescaler", d, 8'h83);

    for (int p = 0; p < 4; p++) begin
      int per;
      per = 128 >> p;
      measure(p, 0);
      measure(p, 1);
      measure(p, per / 2);
      measure(p, per - 1);
      if (per < 128) measure(p, per);
      measure(p, 127);
    end

    // R7: disable holds output low, registers writable
    wr(1'b0, 8'h00); wr(1'b1, 8'd127); wr(1'b0, 8'h83);
    for (int i = 0; i < 5; i++) pulse();
    check("R7 enabled high before disable", pwm_out, 1);
    wr(1'b0, 8'h03);
    check("R7 output low after disable", pwm_out, 0);
    wr(1'b1, 8'd9);
    rd(1'b1, d); check("R7 duty writable while disabled", d, 9);
    for (int i = 0; i < 20; i++) pulse();
    check("R7 output stays low while disabled", pwm_out, 0);

    // R8: prescaler change keeps counter
    wr(1'b1, 8'd12); wr(1'b0, 8'h80);
    for (int i = 0; i < 10; i++) pulse();
    check("R8 high at count 10", pwm_out, 1);
    wr(1'b0, 8'h83);
    pulse();
    check("R8 count 11 still below duty", pwm_out, 1);
    pulse();
    check("R8 count 12 reaches duty", pwm_out, 0);

    // R9: duty change waits for tick
    wr(1'b0, 8'h00); wr(1'b1, 8'd16); wr(1'b0, 8'h83);
    for (int i = 0; i < 3; i++) pulse();
    check("R9 constant high at duty 16", pwm_out, 1);
    wr(1'b1, 8'd0);
    idle(3);
    check("R9 unchanged before tick", pwm_out, 1);
    pulse();
    check("R9 low after tick", pwm_out, 0);

    // R10: no tick, no change
    wr(1'b0, 8'h00); wr(1'b1, 8'd5); wr(1'b0, 8'h83);
    idle(20);
    check("R10 low with no tick", pwm_out, 0);
    for (int i = 0; i < 3; i++) pulse();
    check("R10 high at count 3", pwm_out, 1);
    idle(30);
    check("R10 held during idle", pwm_out, 1);
    pulse(); pulse();
    check("R10 count 5 reaches duty", pwm_out, 0);

    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule